// File: doc/BRIEF.md
# External Program Fetch Interface

This block runs the external instruction-fetch side of a small microcontroller bus. For each accepted request it drives the low address byte onto a shared bidirectional data bus and pulses an address strobe. A transparent-style latch, modelled inside the block, captures that byte when the strobe falls. The upper address nibble goes out on the low half of a general-purpose port. That nibble carries ordinary port output data outside the fetch, and it holds steady from the end of the strobe pulse until the program-store strobe is released.

After the address phase the bus is released for one cycle. The active-low program-store strobe is then asserted for a parameterised number of cycles, and the memory drives the instruction byte during that time. The byte is registered on the clock edge at which the strobe returns high. The top two address bits are decoded into three active-low device selects for 1K-by-8 memories, and those selects are enabled only while the program-store strobe is asserted. The remaining two upper bits go directly to the memories. Memory contents and the CPU that issues requests are outside the block.

Top module: `ext_fetch_if`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ale` is 0, `psen_n` is 1, `bus_oe` is 0, `cs_n` is 3'b111, `instr_valid` is 0 and `busy` is 0.
- R2: A request sampled high in idle starts this sequence on the next edge. One cycle has `ale`=1 with `bus_oe`=1 and `bus_out` equal to address bits [7:0]. One cycle has `ale`=0 with the bus still driven. One cycle has the bus released and `psen_n`=1. Then `PSEN_CYCLES` cycles have `psen_n`=0 and `bus_oe`=0, after which the block is idle again.
- R3: `addr_lat` takes the bus value present while `ale` is high and holds it after `ale` falls, until the next strobe.
- R4: In idle and in the strobe cycle, `port_lo` shows `port_io` as registered on the previous edge. From the cycle after the strobe through the last program-store cycle, `port_lo` shows address bits [11:8].
- R5: `mem_a_hi` always equals `port_lo[1:0]`, which are address bits [9:8] during a fetch.
- R6: `cs_n[k]` is low exactly when `psen_n` is low and `port_lo[3:2]` equals k, for k = 0, 1, 2. Code 3 asserts no select.
- R7: `instr_data` takes `bus_in` as sampled on the edge where `psen_n` returns high. `instr_valid` is high for exactly that one following cycle.
- R8: `fetch_req` and `fetch_addr` are ignored while `busy` is high. The address of the fetch in progress stays on `port_lo`, and no second strobe appears before idle.
- R9: Changes to `port_io` during a fetch do not reach `port_lo` until the fetch ends. The new value appears in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Start a fetch (sampled in idle) |
| fetch_addr | input | 12 | Program address to fetch |
| port_io | input | 4 | Port output data for the shared nibble |
| bus_in | input | 8 | Value read from the shared bus |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus drive enable |
| ale | output | 1 | Address strobe |
| psen_n | output | 1 | Program-store strobe, active low |
| port_lo | output | 4 | Shared nibble: port data or address [11:8] |
| addr_lat | output | 8 | Latched low address byte |
| mem_a_hi | output | 2 | Address bits passed straight to the memories |
| cs_n | output | 3 | Active-low device selects |
| instr_data | output | 8 | Fetched instruction byte |
| instr_valid | output | 1 | One-cycle pulse with a new byte |
| busy | output | 1 | Fetch in progress |

## Verification
The shared nibble is the point of contention. A port-data update and the address hold can land in the same cycle, because the CPU may write new port data while a fetch owns the nibble. The bench changes `port_io` in the bus-release cycle and checks that `port_lo` keeps the address through every program-store cycle and that the device select stays tied to the address code. It then checks that the new port value shows up in the first idle cycle. A request held high across a fetch is used to show that new requests cannot break into the address phase.

// File: rtl/ext_fetch_pkg.sv
package ext_fetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ALE   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_FLOAT = 3'd3,
    ST_PSEN  = 3'd4
  } fetch_state_e;
endpackage

// File: rtl/ext_fetch_seq.sv
module ext_fetch_seq
  import ext_fetch_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 8,
  parameter int PSEN_CYCLES = 2,
  localparam int CNT_W      = (PSEN_CYCLES > 1) ? $clog2(PSEN_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_cur,
  output logic              addr_phase_d,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              ale,
  output logic              psen_n,
  output logic [DATA_W-1:0] instr_data,
  output logic              instr_valid,
  output logic              busy
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PSEN_CYCLES - 1);

  fetch_state_e       state_q, state_d;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               accept;
  logic               sample_d;
  logic               drive_d;

  assign accept   = (state_q == ST_IDLE) && fetch_req;
  assign addr_cur = accept ? fetch_addr : addr_q;
  assign sample_d = (state_q == ST_PSEN) && (cnt_q == CNT_LAST);
  assign drive_d  = (state_d == ST_ALE) || (state_d == ST_ADDR);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (fetch_req) state_d = ST_ALE;
      ST_ALE:   state_d = ST_ADDR;
      ST_ADDR:  state_d = ST_FLOAT;
      ST_FLOAT: state_d = ST_PSEN;
      ST_PSEN:  if (cnt_q == CNT_LAST) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign addr_phase_d = (state_d == ST_ADDR) || (state_d == ST_FLOAT) ||
                        (state_d == ST_PSEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      addr_q      <= '0;
      bus_out     <= '0;
      bus_oe      <= 1'b0;
      ale         <= 1'b0;
      psen_n      <= 1'b1;
      instr_data  <= '0;
      instr_valid <= 1'b0;
      busy        <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) addr_q <= fetch_addr;
      if (state_q == ST_PSEN) cnt_q <= cnt_q + 1'b1;
      else                    cnt_q <= '0;
      bus_out     <= drive_d ? addr_cur[DATA_W-1:0] : '0;
      bus_oe      <= drive_d;
      ale         <= (state_d == ST_ALE);
      psen_n      <= (state_d != ST_PSEN);
      instr_valid <= sample_d;
      if (sample_d) instr_data <= bus_in;
      busy        <= (state_d != ST_IDLE);
    end
  end
endmodule

// File: rtl/ext_fetch_addr_latch.sv
module ext_fetch_addr_latch #(
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe,
  input  logic [LO_W-1:0] bus_val,
  output logic [LO_W-1:0] lat_q
);
  always_ff @(posedge clk) begin
    if (rst)         lat_q <= '0;
    else if (strobe) lat_q <= bus_val;
  end
endmodule

// File: rtl/ext_fetch_port_mux.sv
module ext_fetch_port_mux #(
  parameter int HI_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            addr_phase_d,
  input  logic [HI_W-1:0] addr_hi,
  input  logic [HI_W-1:0] io_val,
  output logic [HI_W-1:0] nib_q
);
  always_ff @(posedge clk) begin
    if (rst) nib_q <= '0;
    else     nib_q <= addr_phase_d ? addr_hi : io_val;
  end
endmodule

// File: rtl/ext_fetch_cs_decode.sv
module ext_fetch_cs_decode #(
  parameter int SEL_W  = 2,
  parameter int NUM_CS = 3
) (
  input  logic             psen_n,
  input  logic [SEL_W-1:0] sel,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
    assign cs_n[k] = !((!psen_n) && (sel == SEL_W'(k)));
  end
endmodule

// File: rtl/ext_fetch_if.sv
module ext_fetch_if #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 2,
  parameter int NUM_CS      = 3,
  parameter int PSEN_CYCLES = 2,
  localparam int HI_W       = ADDR_W - DATA_W,
  localparam int PASS_W     = HI_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [HI_W-1:0]   port_io,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              ale,
  output logic              psen_n,
  output logic [HI_W-1:0]   port_lo,
  output logic [DATA_W-1:0] addr_lat,
  output logic [PASS_W-1:0] mem_a_hi,
  output logic [NUM_CS-1:0] cs_n,
  output logic [DATA_W-1:0] instr_data,
  output logic              instr_valid,
  output logic              busy
);
  logic [ADDR_W-1:0] addr_cur;
  logic              addr_phase_d;
  logic [DATA_W-1:0] bus_wire;

  assign bus_wire = bus_oe ? bus_out : bus_in;

  ext_fetch_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSEN_CYCLES(PSEN_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .bus_in(bus_in), .addr_cur(addr_cur), .addr_phase_d(addr_phase_d),
    .bus_out(bus_out), .bus_oe(bus_oe), .ale(ale), .psen_n(psen_n),
    .instr_data(instr_data), .instr_valid(instr_valid), .busy(busy)
  );

  ext_fetch_addr_latch #(.LO_W(DATA_W)) u_lat (
    .clk(clk), .rst(rst), .strobe(ale), .bus_val(bus_wire), .lat_q(addr_lat)
  );

  ext_fetch_port_mux #(.HI_W(HI_W)) u_port (
    .clk(clk), .rst(rst), .addr_phase_d(addr_phase_d),
    .addr_hi(addr_cur[ADDR_W-1:DATA_W]), .io_val(port_io), .nib_q(port_lo)
  );

  assign mem_a_hi = port_lo[PASS_W-1:0];

  ext_fetch_cs_decode #(.SEL_W(SEL_W), .NUM_CS(NUM_CS)) u_cs (
    .psen_n(psen_n), .sel(port_lo[HI_W-1:PASS_W]), .cs_n(cs_n)
  );
endmodule

// File: rtl/ext_fetch_if_chk.sv
module ext_fetch_if_chk #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 4,
  parameter int NUM_CS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ale,
  input logic              psen_n,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_out,
  input logic [DATA_W-1:0] addr_lat,
  input logic [HI_W-1:0]   port_lo,
  input logic [NUM_CS-1:0] cs_n,
  input logic              instr_valid
);
  p_ale_drives_bus_r2: assert property (@(posedge clk) disable iff (rst)
    ale |-> bus_oe);
  p_psen_floats_bus_r2: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> !bus_oe);
  p_latch_holds_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> (addr_lat == $past(bus_out)));
  p_nibble_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (!psen_n && $past(!psen_n)) |-> $stable(port_lo));
  p_cs_single_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  p_cs_gated_r6: assert property (@(posedge clk) disable iff (rst)
    psen_n |-> (cs_n == '1));
  p_valid_on_release_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(psen_n) |-> instr_valid);
endmodule

bind ext_fetch_if ext_fetch_if_chk #(
  .DATA_W(DATA_W), .HI_W(HI_W), .NUM_CS(NUM_CS)
) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .bus_oe(bus_oe),
  .bus_out(bus_out), .addr_lat(addr_lat), .port_lo(port_lo), .cs_n(cs_n),
  .instr_valid(instr_valid)
);

// File: tb/ext_fetch_if_tb.sv
module ext_fetch_if_tb;
  localparam int NPS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_req = 1'b0;
  logic [11:0] fetch_addr = '0;
  logic [3:0]  port_io = '0;
  logic [7:0]  bus_in = '0;
  logic [7:0]  bus_out, addr_lat, instr_data;
  logic        bus_oe, ale, psen_n, instr_valid, busy;
  logic [3:0]  port_lo;
  logic [1:0]  mem_a_hi;
  logic [2:0]  cs_n;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ext_fetch_if #(.PSEN_CYCLES(NPS)) u_dut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .port_io(port_io), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .ale(ale), .psen_n(psen_n), .port_lo(port_lo), .addr_lat(addr_lat),
    .mem_a_hi(mem_a_hi), .cs_n(cs_n), .instr_data(instr_data),
    .instr_valid(instr_valid), .busy(busy)
  );

  // {addr[11:0], port data[3:0], instruction byte[7:0]}
  localparam logic [23:0] VEC [0:5] = '{
    24'h0A5_3_C3, 24'h47E_9_5A, 24'h8FF_6_01,
    24'hC12_F_7E, 24'h3FF_0_FF, 24'hB00_5_80
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_cs(input logic [1:0] code);
    exp_cs = (code == 2'd3) ? 3'b111 : ~(3'b001 << code);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_fetch(input logic [11:0] a, input logic [3:0] io, input logic [7:0] d);
    @(negedge clk);
    port_io = io;
    step();                               // port data registered in idle
    chk("R4 idle port", port_lo, io);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a;
    step();                               // strobe cycle
    fetch_req = 1'b0;
    chk("R2 ale high", ale, 1);
    chk("R2 bus driven", bus_oe, 1);
    chk("R2 low byte", bus_out, a[7:0]);
    chk("R4 port at strobe", port_lo, io);
    chk("R8 busy", busy, 1);
    step();                               // address hold
    chk("R2 ale low", ale, 0);
    chk("R2 bus held", bus_oe, 1);
    chk("R3 latched byte", addr_lat, a[7:0]);
    chk("R4 port addr", port_lo, a[11:8]);
    chk("R5 pass bits", mem_a_hi, a[9:8]);
    step();                               // bus released
    chk("R2 float", bus_oe, 0);
    chk("R2 psen idle", psen_n, 1);
    chk("R6 no cs", cs_n, 3'b111);
    for (int i = 0; i < NPS; i++) begin
      @(negedge clk);
      bus_in = (i == NPS - 1) ? d : ~d;
      step();
      chk("R2 psen low", psen_n, 0);
      chk("R2 bus off", bus_oe, 0);
      chk("R6 cs decode", cs_n, exp_cs(a[11:10]));
      chk("R3 latch kept", addr_lat, a[7:0]);
    end
    step();                               // strobe released, byte captured
    chk("R7 psen high", psen_n, 1);
    chk("R7 valid", instr_valid, 1);
    chk("R7 data", instr_data, d);
    chk("R1 cs idle", cs_n, 3'b111);
    step();
    chk("R7 single pulse", instr_valid, 0);
    chk("R8 idle", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1 ale", ale, 0);
    chk("R1 psen", psen_n, 1);
    chk("R1 oe", bus_oe, 0);
    chk("R1 cs", cs_n, 3'b111);
    chk("R1 valid", instr_valid, 0);
    chk("R1 busy", busy, 0);
    @(negedge clk); rst = 1'b0;
    step();
    chk("R1 after reset", {ale, psen_n, bus_oe, busy}, 4'b0100);

    foreach (VEC[v]) do_fetch(VEC[v][23:12], VEC[v][11:8], VEC[v][7:0]);

    // R8: request held high and address changed mid-fetch
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 12'h5A1; port_io = 4'h2;
    step();
    @(negedge clk); fetch_addr = 12'hE3C;
    step();
    chk("R8 addr kept", port_lo, 4'h5);
    chk("R8 no restrobe", ale, 0);
    step();
    @(negedge clk); fetch_req = 1'b0;
    for (int i = 0; i < NPS; i++) begin
      step();
      chk("R8 port kept", port_lo, 4'h5);
      chk("R8 cs of first", cs_n, exp_cs(2'd1));
    end
    step();
    chk("R8 back idle", ale, 0);
    step(); step();

    // R9: port data written while the fetch owns the nibble
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 12'hB77; port_io = 4'h1;
    step();
    fetch_req = 1'b0;
    step(); step();                       // in release cycle
    @(negedge clk); port_io = 4'hD;
    for (int i = 0; i < NPS; i++) begin
      step();
      chk("R9 addr held", port_lo, 4'hB);
      chk("R9 cs code 2", cs_n, 3'b011);
    end
    step();
    chk("R9 new port data", port_lo, 4'hD);
    chk("R5 pass follows port", mem_a_hi, 2'b01);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule